// File: doc/BRIEF.md
# Two-Digit Starburst Character Driver

This block drives two 14-segment starburst character positions, each with a decimal point, from 8-bit ASCII codes. Software-side logic writes a character code and a decimal-point bit into either of two character holding registers. An internal glyph ROM turns each printable code into a segment word. The two positions share one set of segment lines and are time-multiplexed: a digit-select output picks the lit position, and it alternates at a prescaled rate.

Besides showing the two written characters, the block has two animated modes. In message mode a small message memory is shown through a two-character window. The window steps one character to the left after a programmable number of refresh periods and wraps at the end of the message. In sweep mode the window walks through every glyph code from 32 to 127 and then starts again at 32.

Top module: `starburst_pair_drv`

## Requirements
- R1: While reset is high and on the first cycle after it, `digit_sel` is 0 and both segment buses are 0. Both character registers reset to code 0x20 (space) with the decimal point off, and the display mode behaves as static.
- R2: In static mode (`mode` 0 or 3), a write with `wr_en` high stores `wr_char` and `wr_dp` into the position given by `wr_digit`. That position then shows glyph(`wr_char`). The 16-bit segment word is `{seg_hi, seg_lo}`, and bit 15 (`seg_hi[7]`) is the decimal point.
- R3: The glyph word has these values: space is 0x0000, '-' is 0x00C0, '0' is 0x0C3F, '8' is 0x00FF, 'A' is 0x00F7 and 'X' is 0x2D00. Bit 14 of the segment word is never set.
- R4: Each lowercase letter 'a' to 'z' shows the same segment pattern as its uppercase letter.
- R5: Codes below 32, codes 127 and above, and printable codes that are not space, '-', a digit or a letter all show with every glyph segment off. Only the decimal point may be lit for such a code.
- R6: `digit_sel` toggles once every 2^PRE_W clocks. One refresh period is 2^(PRE_W+1) clocks and starts when position 0 is selected.
- R7: On the first cycle after each change of `digit_sel`, both segment buses are 0.
- R8: In message mode (`mode` 1), position 0 shows msg[p] and position 1 shows msg[p+1]. Here p+1 wraps to 0 after index `msg_last`. The decimal point is off in message mode and in sweep mode.
- R9: After entering an animated mode, p starts at 0. Count the refresh-period starts after entry as k = 1, 2, .... At start k the window position is floor(k/(hold_periods+1)), reduced modulo the sequence length.
- R10: In message mode the window position wraps from `msg_last` back to 0.
- R11: In sweep mode (`mode` 2), position 0 shows code 32+p and position 1 shows code 32+((p+1) mod 96), with p running from 0 to 95.
- R12: Any change of `mode` restarts the window at p = 0. Returning to static mode shows the stored characters again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Character register write strobe |
| wr_digit | input | 1 | Position written (0 or 1) |
| wr_char | input | 8 | ASCII code to store |
| wr_dp | input | 1 | Decimal point for the stored character |
| msg_we | input | 1 | Message memory write strobe |
| msg_addr | input | MSG_AW | Message memory write index |
| msg_char | input | 8 | Message character to store |
| msg_last | input | MSG_AW | Index of the last message character |
| hold_periods | input | HOLD_W | Window holds for this value + 1 refresh periods |
| mode | input | 2 | 0/3 static, 1 message, 2 sweep |
| seg_lo | output | 8 | Segment word bits 7:0 |
| seg_hi | output | 8 | Segment word bits 15:8 (bit 7 = decimal point) |
| digit_sel | output | 1 | Lit position |

## Verification
The bench aims at the glyph fold for lowercase letters, at the blank class (control codes, DEL, codes at 128 and above, punctuation) and at the one-cycle blank at every position switch. Getting the fold wrong would show lowercase letters dark. A missing blank would leave the previous glyph ghosting onto the other position. Message and sweep runs check both window characters on every refresh period, across the wrap points at `msg_last` and at code 127. A design that steps at the wrong boundary, skips the wrap, or keeps its old position after a mode change would show the wrong glyph on some visit. Switching back to static mode must bring back the stored characters untouched by the animation.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_MSG    = 2'd1,
    MODE_SWEEP  = 2'd2,
    MODE_STILL  = 2'd3
  } disp_mode_e;

  localparam int GLYPH_W     = 15;
  localparam int FIRST_CODE  = 32;
  localparam int GLYPH_COUNT = 96;
  localparam int NUM_DIGITS  = 2;
endpackage

// File: rtl/sbd_refresh.sv
module sbd_refresh #(
  parameter int PRE_W = 14
) (
  input  logic clk,
  input  logic rst,
  output logic sel,
  output logic period_tick
);
  logic [PRE_W-1:0] pre_q;
  logic             wrap;

  assign wrap        = &pre_q;
  assign period_tick = wrap & sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      sel   <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (wrap) sel <= ~sel;
    end
  end
endmodule

// File: rtl/sbd_window.sv
module sbd_window
  import sbd_pkg::*;
#(
  parameter int MSG_DEPTH = 16,
  parameter int HOLD_W    = 8,
  localparam int MSG_AW   = $clog2(MSG_DEPTH),
  localparam int POS_W    = (MSG_AW > 7) ? MSG_AW : 7
) (
  input  logic              clk,
  input  logic              rst,
  input  disp_mode_e        mode,
  input  logic              sel,
  input  logic              period_tick,
  input  logic              msg_we,
  input  logic [MSG_AW-1:0] msg_addr,
  input  logic [7:0]        msg_char,
  input  logic [MSG_AW-1:0] msg_last,
  input  logic [HOLD_W-1:0] hold_periods,
  output logic [7:0]        msg_code,
  output logic [7:0]        sweep_code
);
  logic [7:0]        mem [MSG_DEPTH];
  disp_mode_e        mode_q;
  logic [POS_W-1:0]  pos_q, pos_nx, idx;
  logic [HOLD_W-1:0] cnt_q;
  logic              animated;

  assign animated = (mode == MODE_MSG) || (mode == MODE_SWEEP);

  always_comb begin
    if (mode == MODE_SWEEP)
      pos_nx = (pos_q >= POS_W'(GLYPH_COUNT - 1)) ? '0 : pos_q + 1'b1;
    else
      pos_nx = (pos_q >= POS_W'(msg_last)) ? '0 : pos_q + 1'b1;
  end

  assign idx = sel ? pos_nx : pos_q;

  // message store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (msg_we) mem[msg_addr] <= msg_char;
    msg_code <= mem[idx[MSG_AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) sweep_code <= 8'(FIRST_CODE);
    else     sweep_code <= 8'(FIRST_CODE) + 8'(idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_STATIC;
      pos_q  <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode;
      if (!animated || mode != mode_q) begin
        pos_q <= '0;
        cnt_q <= '0;
      end else if (period_tick) begin
        if (cnt_q >= hold_periods) begin
          cnt_q <= '0;
          pos_q <= pos_nx;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sbd_font.sv
module sbd_font
  import sbd_pkg::*;
(
  input  logic               clk,
  input  logic [7:0]         code,
  output logic [GLYPH_W-1:0] pat
);
  // bit map: 0 top, 1 upper right, 2 lower right, 3 bottom, 4 lower left,
  // 5 upper left, 6 middle left, 7 middle right, 8 diagonal upper left,
  // 9 upper centre, 10 diagonal upper right, 11 diagonal lower left,
  // 12 lower centre, 13 diagonal lower right, 14 spare
  function automatic logic [GLYPH_W-1:0] glyph(input logic [7:0] c);
    case (c)
      8'h20: glyph = 15'h0000;
      8'h2D: glyph = 15'h00C0;
      8'h30: glyph = 15'h0C3F;
      8'h31: glyph = 15'h0006;
      8'h32: glyph = 15'h00DB;
      8'h33: glyph = 15'h008F;
      8'h34: glyph = 15'h00E6;
      8'h35: glyph = 15'h00ED;
      8'h36: glyph = 15'h00FD;
      8'h37: glyph = 15'h0007;
      8'h38: glyph = 15'h00FF;
      8'h39: glyph = 15'h00EF;
      8'h41: glyph = 15'h00F7;
      8'h42: glyph = 15'h128F;
      8'h43: glyph = 15'h0039;
      8'h44: glyph = 15'h120F;
      8'h45: glyph = 15'h0079;
      8'h46: glyph = 15'h0071;
      8'h47: glyph = 15'h00BD;
      8'h48: glyph = 15'h00F6;
      8'h49: glyph = 15'h1209;
      8'h4A: glyph = 15'h001E;
      8'h4B: glyph = 15'h2470;
      8'h4C: glyph = 15'h0038;
      8'h4D: glyph = 15'h0536;
      8'h4E: glyph = 15'h2136;
      8'h4F: glyph = 15'h003F;
      8'h50: glyph = 15'h00F3;
      8'h51: glyph = 15'h203F;
      8'h52: glyph = 15'h20F3;
      8'h53: glyph = 15'h00ED;
      8'h54: glyph = 15'h1201;
      8'h55: glyph = 15'h003E;
      8'h56: glyph = 15'h0C30;
      8'h57: glyph = 15'h2836;
      8'h58: glyph = 15'h2D00;
      8'h59: glyph = 15'h1500;
      8'h5A: glyph = 15'h0C09;
      default: glyph = 15'h0000;
    endcase
  endfunction

  logic [7:0] folded;
  assign folded = (code >= 8'h61 && code <= 8'h7A) ? code - 8'd32 : code;

  always_ff @(posedge clk) pat <= glyph(folded);
endmodule

// File: rtl/starburst_pair_drv.sv
module starburst_pair_drv
  import sbd_pkg::*;
#(
  parameter int PRE_W     = 14,
  parameter int MSG_DEPTH = 16,
  parameter int HOLD_W    = 8,
  localparam int MSG_AW   = $clog2(MSG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_digit,
  input  logic [7:0]        wr_char,
  input  logic              wr_dp,
  input  logic              msg_we,
  input  logic [MSG_AW-1:0] msg_addr,
  input  logic [7:0]        msg_char,
  input  logic [MSG_AW-1:0] msg_last,
  input  logic [HOLD_W-1:0] hold_periods,
  input  logic [1:0]        mode,
  output logic [7:0]        seg_lo,
  output logic [7:0]        seg_hi,
  output logic              digit_sel
);
  disp_mode_e         mode_e, mode1;
  logic               sel0, tick;
  logic [7:0]         chr  [NUM_DIGITS];
  logic               cdp  [NUM_DIGITS];
  logic [7:0]         static_q, msg_code, sweep_code, code1;
  logic               dp_q, dp1, dp2, sel1, sel2;
  logic [GLYPH_W-1:0] pat2;

  assign mode_e = disp_mode_e'(mode);

  sbd_refresh #(.PRE_W(PRE_W)) i_refresh (
    .clk(clk), .rst(rst), .sel(sel0), .period_tick(tick)
  );

  sbd_window #(.MSG_DEPTH(MSG_DEPTH), .HOLD_W(HOLD_W)) i_window (
    .clk(clk), .rst(rst), .mode(mode_e), .sel(sel0), .period_tick(tick),
    .msg_we(msg_we), .msg_addr(msg_addr), .msg_char(msg_char),
    .msg_last(msg_last), .hold_periods(hold_periods),
    .msg_code(msg_code), .sweep_code(sweep_code)
  );

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_char
    logic [7:0] c_q;
    logic       d_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        c_q <= 8'h20;
        d_q <= 1'b0;
      end else if (wr_en && wr_digit == 1'(g)) begin
        c_q <= wr_char;
        d_q <= wr_dp;
      end
    end
    assign chr[g] = c_q;
    assign cdp[g] = d_q;
  end

  // stage 1: pick the source for the selected position
  always_ff @(posedge clk) begin
    if (rst) begin
      static_q <= 8'h20;
      dp_q     <= 1'b0;
      sel1     <= 1'b0;
      mode1    <= MODE_STATIC;
    end else begin
      static_q <= chr[sel0];
      dp_q     <= cdp[sel0];
      sel1     <= sel0;
      mode1    <= mode_e;
    end
  end

  always_comb begin
    unique case (mode1)
      MODE_MSG:   begin code1 = msg_code;   dp1 = 1'b0; end
      MODE_SWEEP: begin code1 = sweep_code; dp1 = 1'b0; end
      default:    begin code1 = static_q;   dp1 = dp_q; end
    endcase
  end

  // stage 2: glyph lookup
  sbd_font i_font (.clk(clk), .code(code1), .pat(pat2));

  always_ff @(posedge clk) begin
    if (rst) begin
      dp2  <= 1'b0;
      sel2 <= 1'b0;
    end else begin
      dp2  <= dp1;
      sel2 <= sel1;
    end
  end

  // stage 3: registered outputs, one dark cycle at each position change
  always_ff @(posedge clk) begin
    if (rst) begin
      digit_sel <= 1'b0;
      seg_lo    <= '0;
      seg_hi    <= '0;
    end else begin
      digit_sel <= sel2;
      if (sel2 != digit_sel) begin
        seg_lo <= '0;
        seg_hi <= '0;
      end else begin
        seg_lo <= pat2[7:0];
        seg_hi <= {dp2, pat2[14:8]};
      end
    end
  end
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker #(
  parameter int PRE_W = 14
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic [7:0] seg_lo,
  input logic [7:0] seg_hi,
  input logic       digit_sel
);
  logic             last_sel, seen;
  logic [PRE_W:0]   since_sw;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_sel <= 1'b0;
      seen     <= 1'b0;
      since_sw <= '0;
    end else begin
      last_sel <= digit_sel;
      if (digit_sel != last_sel) begin
        seen     <= 1'b1;
        since_sw <= '0;
      end else begin
        since_sw <= since_sw + 1'b1;
      end
    end
  end

  AST_RESET_DARK: assert property (@(posedge clk)
    $past(rst) |-> (digit_sel == 1'b0 && seg_lo == 8'h00 && seg_hi == 8'h00)); // R1

  AST_SPARE_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    seg_hi[6] == 1'b0); // R3

  AST_SWITCH_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (seen && digit_sel != last_sel) |-> since_sw == (PRE_W+1)'((1 << PRE_W) - 1)); // R6

  AST_BLANK_ON_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (digit_sel != last_sel) |-> (seg_lo == 8'h00 && seg_hi == 8'h00)); // R7

  AST_ANIM_DP_OFF: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd1 || mode == 2'd2) && $past(mode) == mode &&
     $past(mode, 2) == mode && $past(mode, 3) == mode) |-> !seg_hi[7]); // R8
endmodule

bind starburst_pair_drv sbd_checker #(.PRE_W(PRE_W)) i_sbd_checker (
  .clk(clk), .rst(rst), .mode(mode), .seg_lo(seg_lo), .seg_hi(seg_hi),
  .digit_sel(digit_sel)
);

// File: tb/test_starburst_pair_drv.sv
module test_starburst_pair_drv;
  localparam int PRE_W = 3, MSG_DEPTH = 8, HOLD_W = 4, MSG_AW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, wr_digit = 0, wr_dp = 0, msg_we = 0;
  logic [7:0] wr_char = 8'h20, msg_char = 8'h20;
  logic [MSG_AW-1:0] msg_addr = '0, msg_last = '0;
  logic [HOLD_W-1:0] hold_periods = '0;
  logic [1:0] mode = 2'd0;
  logic [7:0] seg_lo, seg_hi;
  logic digit_sel;
  int vectors = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  starburst_pair_drv #(.PRE_W(PRE_W), .MSG_DEPTH(MSG_DEPTH), .HOLD_W(HOLD_W)) i_starburst_pair_drv (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_digit(wr_digit), .wr_char(wr_char),
    .wr_dp(wr_dp), .msg_we(msg_we), .msg_addr(msg_addr), .msg_char(msg_char),
    .msg_last(msg_last), .hold_periods(hold_periods), .mode(mode),
    .seg_lo(seg_lo), .seg_hi(seg_hi), .digit_sel(digit_sel));

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench model of the stated glyphs; known=0 when no expectation is stated
  function automatic logic [15:0] exp_glyph(input logic [7:0] c, output bit known);
    logic [7:0] u;
    u = (c >= 8'h61 && c <= 8'h7A) ? c - 8'd32 : c;
    known = 1;
    case (u)
      8'h20: return 16'h0000;
      8'h2D: return 16'h00C0;
      8'h30: return 16'h0C3F;
      8'h38: return 16'h00FF;
      8'h41: return 16'h00F7;
      8'h58: return 16'h2D00;
      default: begin
        if ((u >= 8'h30 && u <= 8'h39) || (u >= 8'h41 && u <= 8'h5A)) known = 0;
        return 16'h0000;
      end
    endcase
  endfunction

  // waits for position d to come on; checks the dark cycle (R7), returns the next sample
  task automatic show(input logic d, output logic [15:0] word);
    logic p;
    bit hit;
    p = digit_sel;
    hit = 0;
    while (!hit) begin
      @(negedge clk);
      hit = (digit_sel == d) && (p != d);
      p = digit_sel;
    end
    check("R7 dark cycle at switch", {seg_hi, seg_lo}, 16'h0000);
    @(negedge clk);
    word = {seg_hi, seg_lo};
  endtask

  task automatic write_char(input logic d, input logic [7:0] c, input logic dp);
    @(negedge clk);
    wr_en = 1; wr_digit = d; wr_char = c; wr_dp = dp;
    @(negedge clk);
    wr_en = 0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] blank_code(input int unsigned r);
    case (r % 5)
      0: return 8'(r % 32);
      1: return 8'h7F;
      2: return 8'h80 + 8'(r % 128);
      3: return 8'h21 + 8'(r % 12);
      default: return 8'h5B + 8'(r % 6);
    endcase
  endfunction

  task automatic run_msg(input int hold, input int last);
    logic [15:0] w0, w1, g;
    bit kn;
    logic [7:0] msg [5];
    msg = '{8'h30, 8'h38, 8'h41, 8'h58, 8'h2D};
    @(negedge clk);
    hold_periods = HOLD_W'(hold); msg_last = MSG_AW'(last);
    show(1'b1, w0);
    mode = 2'd1;
    for (int k = 1; k <= 3 * (last + 1) + 2; k++) begin
      int p;
      p = (k / (hold + 1)) % (last + 1);
      show(1'b0, w0);
      g = exp_glyph(msg[p], kn);
      check("R8/R9/R12 message window position 0", w0, g);
      show(1'b1, w1);
      g = exp_glyph(msg[(p + 1) % (last + 1)], kn);
      check("R8/R10 message window position 1", w1, g);
    end
  endtask

  initial begin
    logic [15:0] w, a, b;
    bit kn;
    int unsigned r;
    r = $urandom(32'h1D5EED);
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {seg_hi, seg_lo, 7'd0, digit_sel}, 24'd0);
    @(negedge clk); rst = 0;
    check("R1 first cycle after reset", {seg_hi, seg_lo, 7'd0, digit_sel}, 24'd0);
    show(1'b0, w); check("R1 position 0 space", w, 16'h0000);
    show(1'b1, w); check("R1 position 1 space", w, 16'h0000);

    begin : period_meas
      int t0;
      show(1'b0, w); t0 = cycles;
      show(1'b0, w);
      check("R6 refresh period clocks", 16'(cycles - t0), 16'(1 << (PRE_W + 1)));
    end

    // directed glyphs and dp
    write_char(1'b0, 8'h41, 1'b1); write_char(1'b1, 8'h58, 1'b0);
    show(1'b0, w); check("R2/R3 'A' with dp on position 0", w, 16'h80F7);
    show(1'b1, w); check("R2/R3 'X' on position 1", w, 16'h2D00);
    write_char(1'b1, 8'h7F, 1'b1);
    show(1'b1, w); check("R5 DEL shows only dp", w, 16'h8000);
    write_char(1'b0, 8'h7A, 1'b0); write_char(1'b1, 8'h5A, 1'b0);
    show(1'b0, a); show(1'b1, b); check("R4 'z' equals 'Z'", a, b);

    // constrained random static writes
    for (int i = 0; i < 40; i++) begin
      logic [7:0] c;
      logic d, dp;
      r = $urandom;
      d = r[8]; dp = r[9];
      case (r % 3)
        0: begin
          logic [7:0] set [8];
          set = '{8'h20, 8'h2D, 8'h30, 8'h38, 8'h41, 8'h58, 8'h61, 8'h78};
          c = set[(r >> 4) % 8];
        end
        1: c = blank_code(r >> 3);
        default: c = 8'h61 + 8'((r >> 4) % 26);
      endcase
      if (r % 3 == 2) begin
        write_char(1'b0, c, dp); write_char(1'b1, c - 8'd32, dp);
        show(1'b0, a); show(1'b1, b);
        check("R4 lowercase equals uppercase", a, b);
      end else begin
        write_char(d, c, dp);
        show(d, w);
        a = exp_glyph(c, kn);
        check(r % 3 == 1 ? "R5 blank code" : "R2/R3 stated glyph", w, {dp, a[14:0]});
      end
    end
    write_char(1'b0, 8'h38, 1'b1); write_char(1'b1, 8'h2D, 1'b0);

    // message memory
    begin : fill
      logic [7:0] msg [5];
      msg = '{8'h30, 8'h38, 8'h41, 8'h58, 8'h2D};
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        msg_we = 1; msg_addr = MSG_AW'(i); msg_char = msg[i];
      end
      @(negedge clk); msg_we = 0;
    end
    run_msg(2, 4);

    // sweep through all glyph codes with wrap at 127
    @(negedge clk); hold_periods = '0;
    show(1'b1, w);
    mode = 2'd2;
    for (int k = 1; k <= 100; k++) begin
      logic [7:0] c0, c1;
      c0 = 8'(32 + (k % 96)); c1 = 8'(32 + ((k + 1) % 96));
      show(1'b0, a);
      w = exp_glyph(c0, kn);
      if (kn) check("R11 sweep position 0", a, w);
      show(1'b1, b);
      w = exp_glyph(c1, kn);
      if (kn) check("R11 sweep position 1", b, w);
    end

    // back to static: stored characters return, then message restarts at 0
    @(negedge clk); mode = 2'd3;
    show(1'b0, w); show(1'b0, w); check("R12 static again position 0", w, 16'h80FF);
    show(1'b1, w); check("R12 static again position 1", w, 16'h00C0);
    @(negedge clk); mode = 2'd0;
    run_msg(0, 2);
    @(negedge clk); mode = 2'd0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule